// File: doc/BRIEF.md
# Double-Buffered Peripheral DMA Channel

This block is one DMA channel that carries bytes from memory to a peripheral. It has two buffer descriptor slots, and software fills them in turn. Each slot holds a byte count and a start address. While the channel works through one slot, software can fill the other, so the peripheral sees an unbroken byte stream across buffer boundaries. A four-state occupancy machine reports how many slots are loaded. Three interrupt sources tell software when a slot has been freed, when the channel has run out of work, and when the memory port returned a bus error.

Software drives the channel through a small register file. It sets the enable bit, which moves the channel into its waiting state. It then writes a slot's count followed by that slot's base address, and the base write commits the load. From then on it refills whichever slot the channel frees. For each byte the peripheral asks for with a request level, the channel reads that byte from memory and hands it over with a one-cycle acknowledge. To shut the channel down, software masks the buffer interrupts, waits for the channel to drain, and then clears the enable bit.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads 0. This covers the status state field (bits [5:4] at offset 0x0C), the control register at 0x00, the flag register at 0x04, the remaining count at 0x14 and the port select at 0x08. The `irq` output is 0, and the load pointer names slot 0.
- R2: Status bits [5:4] encode the state: 0 idle, 1 stall, 2 on and 3 next. Setting the enable bit (control bit 4) in idle moves the channel to stall. With enable clear, stall moves to idle.
- R3: A slot's registers are at count 0x20 and base 0x24 for slot 0, and at count 0x30 and base 0x34 for slot 1. Count and base writes are stored only for the slot the load pointer names, and only while the state is stall or on with enable set. Writes that do not meet these conditions leave the stored values unchanged. A base write that is stored commits a load, and each load toggles the load pointer.
- R4: A load moves the state from stall to on, and from on to next.
- R5: Each active buffer delivers its bytes in address order, base+0 up to base+count-1. Each byte is read from memory and presented on `per_data` with a one-cycle `per_ack`. Buffers are served in the order they were loaded. The remaining count register reloads from the count of the buffer that starts, and drops by one for each byte.
- R6: When a buffer completes while another buffer is queued, the channel sets the next-free-buffer flag (flag bit 1) and the state becomes on. A load that commits in the same cycle as the completion counts as queued.
- R7: When a buffer completes with nothing queued, the channel sets the stall flag (flag bit 0) and the state becomes stall.
- R8: A bus error on the memory port sets the error flag (flag bit 3). The errored byte is not delivered, but it is still counted. Every flag stays set until software writes a 1 to its bit at offset 0x04.
- R9: `irq` is high exactly when at least one flag is set together with its enable bit. The enable bits are control bit 0 for the stall flag, bit 1 for the next-free-buffer flag and bit 3 for the error flag.
- R10: In shutdown, software clears the interrupt enables and waits until the state is below on, then writes 0 to control. The state then reaches idle, and the load pointer returns to slot 0 for the next enable.
- R11: A write to the port select register (offset 0x08) is stored, reads back, and drives `per_port`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory read request, held until ack or error |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Memory read completed |
| mem_err | input | 1 | Memory bus error response |
| per_req | input | 1 | Peripheral wants a byte |
| per_ack | output | 1 | One-cycle strobe: `per_data` is valid |
| per_data | output | 8 | Byte to the peripheral |
| per_port | output | PORT_W | Selected peripheral port |
| irq | output | 1 | Level interrupt |

## Verification
A buffer can complete in the same clock edge at which software commits a load into the free slot. The channel must then chain straight to the new buffer and raise the next-free-buffer flag, not the stall flag. The bench provokes this by loading a one-byte buffer with the peripheral requesting. It then sweeps the cycle of the second base write across the completion edge. For each offset it judges the outcome from the byte stream and the flags: the delivered bytes must match both buffers in order, and the next-free-buffer flag must be set exactly when the second load commits at or before the completion edge.

// File: rtl/dmac_pkg.sv
// Package: shared register map, bit positions and state types of the
// double-buffered DMA channel. Assumes an 8-bit register offset bus and a
// 32-bit register data bus.
package dmac_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;
    localparam int BYTE_W = 8;

    localparam logic [REG_AW-1:0] OFF_CTRL = 8'h00;
    localparam logic [REG_AW-1:0] OFF_FLAG = 8'h04;
    localparam logic [REG_AW-1:0] OFF_PORT = 8'h08;
    localparam logic [REG_AW-1:0] OFF_STAT = 8'h0C;
    localparam logic [REG_AW-1:0] OFF_REM  = 8'h14;
    localparam logic [REG_AW-1:0] OFF_CNT0 = 8'h20;
    localparam logic [REG_AW-1:0] OFF_BAS0 = 8'h24;
    localparam logic [REG_AW-1:0] OFF_CNT1 = 8'h30;
    localparam logic [REG_AW-1:0] OFF_BAS1 = 8'h34;

    localparam int BIT_STALL = 0;
    localparam int BIT_NFB   = 1;
    localparam int BIT_ERR   = 3;
    localparam int BIT_EN    = 4;
    localparam int STAT_LSB  = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_ON    = 2'd2,
        ST_NEXT  = 2'd3
    } chan_state_e;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_MEM  = 2'd1,
        MV_GIVE = 2'd2
    } mover_ph_e;

    // Offset of a slot's count (is_base=0) or base (is_base=1) register.
    function automatic logic [REG_AW-1:0] slot_reg(input logic slot, input logic is_base);
        logic [REG_AW-1:0] off;
        off = slot ? OFF_CNT1 : OFF_CNT0;
        if (is_base) off = off + 8'h04;
        return off;
    endfunction
endpackage

// File: rtl/dmac_slot_fsm.sv
// Slot and occupancy sequencer: stores the two descriptors, keeps the load
// pointer and the active slot, and runs the idle/stall/on/next machine.
// Assumes the byte mover reports completion through `done` only while a
// buffer is armed, and that it accepts a `start` in the same cycle.
module dmac_slot_fsm
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [REG_AW-1:0]            reg_addr,
    input  logic [REG_DW-1:0]            reg_wdata,
    input  logic                         enable,
    input  logic                         done,
    output chan_state_e                  state,
    output logic [1:0][CNT_W-1:0]        slot_cnt,
    output logic [1:0][ADDR_W-1:0]       slot_base,
    output logic                         start,
    output logic [CNT_W-1:0]             start_cnt,
    output logic [ADDR_W-1:0]            start_base,
    output logic                         ev_stall,
    output logic                         ev_nfb
);
    chan_state_e            st_q, st_d;
    logic [1:0][CNT_W-1:0]  cnt_q;
    logic [1:0][ADDR_W-1:0] base_q;
    logic                   wr_slot_q, act_slot_q, start_slot;
    logic                   can_load, hit_cnt, load;
    logic                   unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign state     = st_q;
    assign slot_cnt  = cnt_q;
    assign slot_base = base_q;

    // Accept descriptor writes only into the free slot named by the pointer.
    assign can_load = enable && (st_q == ST_STALL || st_q == ST_ON);
    assign hit_cnt  = can_load && reg_wr && (reg_addr == slot_reg(wr_slot_q, 1'b0));
    assign load     = can_load && reg_wr && (reg_addr == slot_reg(wr_slot_q, 1'b1));

    // Next-state, buffer start and interrupt event decode.
    always_comb begin
        st_d       = st_q;
        start      = 1'b0;
        start_slot = wr_slot_q;
        start_cnt  = cnt_q[wr_slot_q];
        start_base = reg_wdata[ADDR_W-1:0];
        ev_stall   = 1'b0;
        ev_nfb     = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (enable) st_d = ST_STALL;
            end
            ST_STALL: begin
                if (load) begin
                    st_d  = ST_ON;
                    start = 1'b1;
                end else if (!enable) begin
                    st_d = ST_IDLE;
                end
            end
            ST_ON: begin
                if (done && load) begin
                    start  = 1'b1;
                    ev_nfb = 1'b1;
                end else if (done) begin
                    st_d     = ST_STALL;
                    ev_stall = 1'b1;
                end else if (load) begin
                    st_d = ST_NEXT;
                end
            end
            ST_NEXT: begin
                if (done) begin
                    st_d       = ST_ON;
                    start      = 1'b1;
                    start_slot = ~act_slot_q;
                    start_cnt  = cnt_q[~act_slot_q];
                    start_base = base_q[~act_slot_q];
                    ev_nfb     = 1'b1;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State, descriptor storage and slot pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            cnt_q      <= '0;
            base_q     <= '0;
            wr_slot_q  <= 1'b0;
            act_slot_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (hit_cnt) cnt_q[wr_slot_q] <= reg_wdata[CNT_W-1:0];
            if (load) begin
                base_q[wr_slot_q] <= reg_wdata[ADDR_W-1:0];
                wr_slot_q         <= ~wr_slot_q;
            end
            if (start) act_slot_q <= start_slot;
            if (st_d == ST_IDLE) begin
                wr_slot_q  <= 1'b0;
                act_slot_q <= 1'b0;
            end
        end
    end

    // R2
    idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_STALL));
    // R7
    stall_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stall |=> (st_q == ST_STALL));
    // R6
    nfb_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_nfb |=> (st_q == ST_ON));
    // R4
    load_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !done && st_q == ST_STALL) |=> (st_q == ST_ON));
endmodule

// File: rtl/dmac_mover.sv
// Byte mover: for the armed buffer, waits for a peripheral request, reads one
// byte from memory and hands it over with a one-cycle acknowledge, counting
// errored bytes as moved. Assumes `start` only arrives when idle or on `done`.
module dmac_mover
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   start_cnt,
    input  logic [ADDR_W-1:0]  start_base,
    input  logic               per_req,
    output logic               per_ack,
    output logic [BYTE_W-1:0]  per_data,
    output logic               mem_req,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [BYTE_W-1:0]  mem_rdata,
    input  logic               mem_ack,
    input  logic               mem_err,
    output logic               done,
    output logic               ev_err,
    output logic [CNT_W-1:0]   rem
);
    mover_ph_e          ph_q;
    logic               armed_q, ack_q;
    logic [CNT_W-1:0]   rem_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [BYTE_W-1:0]  data_q;

    assign done     = armed_q && (rem_q == '0) && (ph_q == MV_IDLE);
    assign ev_err   = (ph_q == MV_MEM) && mem_err;
    assign mem_req  = (ph_q == MV_MEM);
    assign mem_addr = addr_q;
    assign per_ack  = ack_q;
    assign per_data = data_q;
    assign rem      = rem_q;

    // Per-byte handshake sequencing and buffer arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q    <= MV_IDLE;
            armed_q <= 1'b0;
            ack_q   <= 1'b0;
            rem_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
        end else begin
            ack_q <= 1'b0;
            case (ph_q)
                MV_IDLE: begin
                    if (armed_q && rem_q != '0 && per_req) ph_q <= MV_MEM;
                end
                MV_MEM: begin
                    if (mem_err) begin
                        rem_q  <= rem_q - 1'b1;
                        addr_q <= addr_q + 1'b1;
                        ph_q   <= MV_IDLE;
                    end else if (mem_ack) begin
                        data_q <= mem_rdata;
                        ack_q  <= 1'b1;
                        rem_q  <= rem_q - 1'b1;
                        addr_q <= addr_q + 1'b1;
                        ph_q   <= MV_GIVE;
                    end
                end
                MV_GIVE: ph_q <= MV_IDLE;
                default: ph_q <= MV_IDLE;
            endcase
            if (done && !start) armed_q <= 1'b0;
            if (start) begin
                armed_q <= 1'b1;
                rem_q   <= start_cnt;
                addr_q  <= start_base;
            end
        end
    end

    // R5
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> !per_ack);
    // R5
    start_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (ph_q == MV_IDLE && (!armed_q || done)));
    // R5
    rem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && (mem_ack || mem_err) && !start) |=> (rem_q == $past(rem_q) - CNT_W'(1)));
endmodule

// File: rtl/dmac_regs.sv
// Register file: control bits, port select, sticky interrupt flags with
// write-one-to-clear, the read-back mux and the combined interrupt level.
// Assumes event inputs are single-cycle pulses from the sequencer and mover.
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [REG_DW-1:0]       reg_wdata,
    output logic [REG_DW-1:0]       reg_rdata,
    input  chan_state_e             state,
    input  logic [CNT_W-1:0]        rem,
    input  logic [1:0][CNT_W-1:0]   slot_cnt,
    input  logic [1:0][ADDR_W-1:0]  slot_base,
    input  logic                    ev_stall,
    input  logic                    ev_nfb,
    input  logic                    ev_err,
    output logic                    enable,
    output logic [PORT_W-1:0]       port_sel,
    output logic                    irq
);
    logic              en_stall_q, en_nfb_q, en_err_q, enable_q;
    logic              fl_stall_q, fl_nfb_q, fl_err_q;
    logic [PORT_W-1:0] port_q;
    logic              wr_ctrl, wr_flag, wr_port;
    logic              unused_wbits;

    assign unused_wbits = ^reg_wdata;
    assign wr_ctrl  = reg_wr && (reg_addr == OFF_CTRL);
    assign wr_flag  = reg_wr && (reg_addr == OFF_FLAG);
    assign wr_port  = reg_wr && (reg_addr == OFF_PORT);
    assign enable   = enable_q;
    assign port_sel = port_q;
    assign irq      = (fl_stall_q && en_stall_q) || (fl_nfb_q && en_nfb_q) || (fl_err_q && en_err_q);

    // Control and port select storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_stall_q <= 1'b0;
            en_nfb_q   <= 1'b0;
            en_err_q   <= 1'b0;
            enable_q   <= 1'b0;
            port_q     <= '0;
        end else begin
            if (wr_ctrl) begin
                en_stall_q <= reg_wdata[BIT_STALL];
                en_nfb_q   <= reg_wdata[BIT_NFB];
                en_err_q   <= reg_wdata[BIT_ERR];
                enable_q   <= reg_wdata[BIT_EN];
            end
            if (wr_port) port_q <= reg_wdata[PORT_W-1:0];
        end
    end

    // Sticky flags: an event sets, a written 1 clears, the event wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_stall_q <= 1'b0;
            fl_nfb_q   <= 1'b0;
            fl_err_q   <= 1'b0;
        end else begin
            fl_stall_q <= ev_stall || (fl_stall_q && !(wr_flag && reg_wdata[BIT_STALL]));
            fl_nfb_q   <= ev_nfb   || (fl_nfb_q   && !(wr_flag && reg_wdata[BIT_NFB]));
            fl_err_q   <= ev_err   || (fl_err_q   && !(wr_flag && reg_wdata[BIT_ERR]));
        end
    end

    // Read-back multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_CTRL: begin
                reg_rdata[BIT_STALL] = en_stall_q;
                reg_rdata[BIT_NFB]   = en_nfb_q;
                reg_rdata[BIT_ERR]   = en_err_q;
                reg_rdata[BIT_EN]    = enable_q;
            end
            OFF_FLAG: begin
                reg_rdata[BIT_STALL] = fl_stall_q;
                reg_rdata[BIT_NFB]   = fl_nfb_q;
                reg_rdata[BIT_ERR]   = fl_err_q;
            end
            OFF_PORT: reg_rdata = REG_DW'(port_q);
            OFF_STAT: reg_rdata[STAT_LSB +: 2] = state;
            OFF_REM:  reg_rdata = REG_DW'(rem);
            OFF_CNT0: reg_rdata = REG_DW'(slot_cnt[0]);
            OFF_BAS0: reg_rdata = REG_DW'(slot_base[0]);
            OFF_CNT1: reg_rdata = REG_DW'(slot_cnt[1]);
            OFF_BAS1: reg_rdata = REG_DW'(slot_base[1]);
            default:  reg_rdata = '0;
        endcase
    end

    // R8
    err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_err |=> fl_err_q);
    // R8
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_err_q && !wr_flag) |=> fl_err_q);
    // R9
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_stall_q && !en_nfb_q && !en_err_q) |-> !irq);
endmodule

// File: rtl/dbuf_dma_chan.sv
// Top: double-buffered memory-to-peripheral DMA channel. Connects the
// register file, the slot/occupancy sequencer and the byte mover. Assumes a
// memory port that answers each request with one ack or error pulse.
module dbuf_dma_chan
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16,
    parameter int PORT_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [REG_DW-1:0]    reg_wdata,
    output logic [REG_DW-1:0]    reg_rdata,
    output logic                 mem_req,
    output logic [ADDR_W-1:0]    mem_addr,
    input  logic [BYTE_W-1:0]    mem_rdata,
    input  logic                 mem_ack,
    input  logic                 mem_err,
    input  logic                 per_req,
    output logic                 per_ack,
    output logic [BYTE_W-1:0]    per_data,
    output logic [PORT_W-1:0]    per_port,
    output logic                 irq
);
    chan_state_e            state;
    logic [1:0][CNT_W-1:0]  slot_cnt;
    logic [1:0][ADDR_W-1:0] slot_base;
    logic                   enable, done, start, ev_stall, ev_nfb, ev_err;
    logic [CNT_W-1:0]       start_cnt, rem;
    logic [ADDR_W-1:0]      start_base;

    dmac_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PORT_W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .state(state), .rem(rem),
        .slot_cnt(slot_cnt), .slot_base(slot_base), .ev_stall(ev_stall),
        .ev_nfb(ev_nfb), .ev_err(ev_err), .enable(enable), .port_sel(per_port),
        .irq(irq)
    );

    dmac_slot_fsm #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .enable(enable), .done(done), .state(state),
        .slot_cnt(slot_cnt), .slot_base(slot_base), .start(start),
        .start_cnt(start_cnt), .start_base(start_base), .ev_stall(ev_stall),
        .ev_nfb(ev_nfb)
    );

    dmac_mover #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_mover (
        .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
        .start_base(start_base), .per_req(per_req), .per_ack(per_ack),
        .per_data(per_data), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .mem_err(mem_err),
        .done(done), .ev_err(ev_err), .rem(rem)
    );
endmodule

// File: tb/tb_dbuf_dma_chan.sv
module tb_dbuf_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;
    logic        per_req = 1'b0;
    logic        per_ack;
    logic [7:0]  per_data;
    logic [3:0]  per_port;
    logic        irq;

    int          errors = 0;
    int          checks = 0;
    logic [7:0]  rx [0:63];
    int          rx_n = 0;
    logic        err_on = 1'b0;
    logic [15:0] err_addr = '0;
    logic        ptr = 1'b0;
    logic [31:0] d;

    dbuf_dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .per_req(per_req), .per_ack(per_ack),
        .per_data(per_data), .per_port(per_port), .irq(irq)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // Memory model: answers one request with one ack or error pulse.
    always @(negedge clk) begin
        if (!mem_req || mem_ack || mem_err) begin
            mem_ack = 1'b0;
            mem_err = 1'b0;
        end else if (err_on && mem_addr == err_addr) begin
            mem_err = 1'b1;
        end else begin
            mem_ack   = 1'b1;
            mem_rdata = pat(mem_addr);
        end
    end

    // Peripheral model: records every delivered byte.
    always @(negedge clk) begin
        if (per_ack && rx_n < 64) begin
            rx[rx_n] = per_data;
            rx_n = rx_n + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(posedge clk);
        #1 reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic load(input logic [15:0] base, input logic [15:0] cnt);
        wr(ptr ? 8'h30 : 8'h20, 32'(cnt));
        wr(ptr ? 8'h34 : 8'h24, 32'(base));
        ptr = ~ptr;
    endtask

    task automatic wait_st(input logic [1:0] s, input string tag);
        logic [31:0] v;
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < 500 && !ok; i++) begin
            rd(8'h0C, v);
            if (v[5:4] == s) ok = 1'b1;
        end
        chk(tag, 32'(ok), 32'd1);
    endtask

    task automatic stream(input string tag, input logic [15:0] ba, input int ca,
                          input logic [15:0] bb, input int cb);
        int bad;
        bad = 0;
        chk({tag, " count"}, 32'(rx_n), 32'(ca + cb));
        for (int i = 0; i < ca + cb && i < 64; i++) begin
            logic [15:0] a;
            a = (i < ca) ? ba + 16'(i) : bb + 16'(i - ca);
            if (rx[i] !== pat(a)) bad++;
        end
        chk({tag, " bytes"}, 32'(bad), 32'd0);
    endtask

    initial begin
        #(20 * 150000);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd(8'h0C, d); chk("R1 state", 32'(d[5:4]), 0);
        rd(8'h00, d); chk("R1 ctrl", d, 0);
        rd(8'h04, d); chk("R1 flags", d, 0);
        rd(8'h14, d); chk("R1 remaining", d, 0);
        rd(8'h08, d); chk("R1 port", d, 0);
        chk("R1 irq", 32'(irq), 0);
        // R3 descriptor write in idle ignored
        wr(8'h20, 32'd5); rd(8'h20, d); chk("R3 idle write", d, 0);
        // R2 enable moves idle to stall
        wr(8'h00, 32'h10); @(posedge clk);
        rd(8'h0C, d); chk("R2 stall code", 32'(d[5:4]), 1);
        // R1 pointer at slot 0: slot-1 count write ignored
        wr(8'h30, 32'd7); rd(8'h30, d); chk("R1 R3 pointer slot0", d, 0);

        // R4 loads step the occupancy
        load(16'h1100, 16'd3);
        rd(8'h0C, d); chk("R4 on", 32'(d[5:4]), 2);
        rd(8'h14, d); chk("R5 remaining reload", d, 3);
        load(16'h2200, 16'd2);
        rd(8'h0C, d); chk("R4 next", 32'(d[5:4]), 3);
        wr(8'h20, 32'd9); rd(8'h20, d); chk("R3 write while full", d, 3);
        rd(8'h34, d); chk("R3 base1 stored", d, 32'h2200);

        // R5 R6 R7 run both buffers
        wr(8'h00, 32'h1B);
        rx_n = 0; per_req = 1'b1;
        wait_st(2'd1, "R7 drained");
        stream("R5 two buffers", 16'h1100, 3, 16'h2200, 2);
        rd(8'h04, d); chk("R6 R7 flags", d, 32'h3);
        chk("R9 irq set", 32'(irq), 1);
        rd(8'h14, d); chk("R5 remaining zero", d, 0);
        wr(8'h04, 32'h2); rd(8'h04, d); chk("R8 clear nfb only", d, 32'h1);
        chk("R9 irq stall", 32'(irq), 1);
        wr(8'h04, 32'h1); rd(8'h04, d); chk("R8 clear stall", d, 0);
        chk("R9 irq clear", 32'(irq), 0);

        // R8 bus error
        err_on = 1'b1; err_addr = 16'h3301; rx_n = 0;
        load(16'h3300, 16'd3);
        wait_st(2'd1, "R8 drained");
        chk("R8 count", 32'(rx_n), 2);
        chk("R8 byte0", 32'(rx[0]), 32'(pat(16'h3300)));
        chk("R8 byte1", 32'(rx[1]), 32'(pat(16'h3302)));
        rd(8'h04, d); chk("R8 error flag", d, 32'h9);
        wr(8'h04, 32'h1);
        chk("R9 irq error", 32'(irq), 1);
        wr(8'h00, 32'h13);
        chk("R9 error masked", 32'(irq), 0);
        rd(8'h04, d); chk("R8 error sticky", d, 32'h8);
        wr(8'h04, 32'h8); rd(8'h04, d); chk("R8 error clear", d, 0);
        err_on = 1'b0;

        // R5 R7 sweep of count pairs
        for (int c0 = 0; c0 < 4; c0++) begin
            for (int c1 = 0; c1 < 4; c1++) begin
                logic [15:0] ba, bb;
                ba = 16'h4000 + 16'(c0 << 8) + 16'(c1 << 4);
                bb = 16'h6000 + 16'(c1 << 8) + 16'(c0 << 4);
                per_req = 1'b0; rx_n = 0;
                wr(8'h04, 32'hB);
                load(ba, 16'(c0));
                load(bb, 16'(c1));
                per_req = 1'b1;
                wait_st(2'd1, "R7 sweep drained");
                stream($sformatf("R5 sweep %0d/%0d", c0, c1), ba, c0, bb, c1);
                rd(8'h04, d); chk("R7 sweep stall flag", 32'(d[0]), 1);
            end
        end

        // R6 completion and load in the same cycle
        for (int k = 2; k < 8; k++) begin
            per_req = 1'b1; rx_n = 0;
            wr(8'h04, 32'hB);
            wr(ptr ? 8'h30 : 8'h20, 32'd1);
            wr(ptr ? 8'h34 : 8'h24, 32'h7000);
            ptr = ~ptr;
            wr(ptr ? 8'h30 : 8'h20, 32'd2);
            repeat (k - 2) @(posedge clk);
            wr(ptr ? 8'h34 : 8'h24, 32'h7100);
            ptr = ~ptr;
            wait_st(2'd1, "R6 edge drained");
            stream($sformatf("R6 edge k=%0d", k), 16'h7000, 1, 16'h7100, 2);
            rd(8'h04, d);
            chk($sformatf("R6 nfb k=%0d", k), 32'(d[1]), (k <= 4) ? 32'd1 : 32'd0);
            chk("R7 edge stall flag", 32'(d[0]), 1);
        end

        // R10 shutdown sequence
        per_req = 1'b0; rx_n = 0;
        load(16'h5000, 16'd2);
        load(16'h5100, 16'd2);
        wr(8'h00, 32'h10);
        per_req = 1'b1;
        wait_st(2'd1, "R10 below on");
        wr(8'h00, 32'h0);
        wait_st(2'd0, "R10 idle");
        stream("R10 drain", 16'h5000, 2, 16'h5100, 2);
        wr(8'h00, 32'h10); @(posedge clk);
        ptr = 1'b0;
        wr(8'h20, 32'd5); rd(8'h20, d); chk("R10 pointer slot0", d, 5);

        // R11 port select
        wr(8'h08, 32'hA); rd(8'h08, d); chk("R11 readback", d, 32'hA);
        chk("R11 per_port", 32'(per_port), 32'hA);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule